// File: doc/BRIEF.md
# Event Interrupt Control and Status Register Bank

This block is the register front end of a 64-event interrupt controller. It sits on a simple 32-bit register bus with an address, a write strobe, write data and combinational read data. It holds four kinds of state: a pending flag per event, an enable flag per event, an enable flag per host interrupt line, and one global enable. It also holds a polarity bit and a detection-mode bit for each event line. A routing and priority stage further down the chip uses the pending and enable vectors, the host enables and the global enable. That stage is not part of this block.

Software can change a state bit in two ways. It can write the bit's index number to a dedicated set or clear address. It can also write a 32-bit mask to a word-wide register, where each one bit acts on its event and each zero bit is ignored. The event input lines set pending flags directly. Each line is first normalised by its polarity bit. In pulse mode a flag is set when the line becomes active. In level mode a flag is set on every cycle the line is active.

Top module: `evt_ctl_regbank`

## Requirements
- R1: After reset, all pending, event-enable and host-enable bits and the global enable are 0, every polarity bit is 1 and every mode bit is 0.
- R2: Writing an event number below 64 to 0x020 sets that event's pending bit, and writing it to 0x024 clears that bit.
- R3: Writing an event number below 64 to 0x028 sets that event's enable bit, and writing it to 0x02C clears that bit.
- R4: Writing a host number from 0 to 9 to 0x034 sets bit n of the host-enable output, and writing it to 0x038 clears that bit.
- R5: An index write carrying an event number of 64 or more, or a host number of 10 or more, leaves all state unchanged.
- R6: The global enable is bit 0 of the register at 0x010 and can be read and written. The other bits of that register read as 0.
- R7: A write to 0x300 (events 0 to 31, event n at bit n) or to 0x304 (events 32 to 63, event n at bit n-32) sets the enable of every event whose bit is 1 and leaves the others unchanged. Reading either clear-mask address or either set-mask address returns the enable word.
- R8: A write to 0x380 or 0x384 clears the enable of every event whose bit is 1. A write to 0x280 or 0x284 clears the pending bit of every event whose bit is 1. Zero bits have no effect. Both pairs use the same word layout as R7.
- R9: The polarity words at 0xD00 and 0xD04 can be read and written, and a 1 means active high. The mode words at 0xD80 and 0xD84 can be read and written, and a 1 means level mode while a 0 means pulse mode. Both pairs use the word layout of R7.
- R10: In pulse mode, a pending bit is set one clock after its line goes from inactive to active. Holding the line active does not set the bit again after it has been cleared.
- R11: In level mode, a pending bit is set on every clock where its line is active, so a clear has no effect while the line is active. After the line becomes inactive, the bit stays set until it is cleared.
- R12: If a line event and a software clear reach the same pending bit in the same cycle, the bit ends up set.
- R13: The raw status words at 0x200 and 0x204 return the pending bits. The index set and clear addresses and every unmapped address read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_in | input | 64 | Raw event lines |
| evt_pend | output | 64 | Pending flag per event |
| evt_en | output | 64 | Enable flag per event |
| host_en | output | 10 | Enable flag per host interrupt line |
| glb_en | output | 1 | Global enable |

## Verification
The bench builds the block with its default values: 64 events in two 32-bit words and 10 host lines. With these values the word-select logic is exercised on both halves, including event 63 at the top of the upper word and event 40 inside it. Both out-of-range boundaries are reached: event number 64 and host number 10 are the first illegal values, and 9 is the highest legal host number. The line tests drive events in pulse mode, in level mode and with active-low polarity, and they include a line event and a clear that land in the same cycle.

// File: rtl/ecr_pkg.sv
package ecr_pkg;
  // Byte offsets of the register map; word n of a multi-word group sits at +4*n
  localparam int A_GLB    = 'h010;
  localparam int A_STSET  = 'h020;
  localparam int A_STCLR  = 'h024;
  localparam int A_ENSET  = 'h028;
  localparam int A_ENCLR  = 'h02C;
  localparam int A_HSET   = 'h034;
  localparam int A_HCLR   = 'h038;
  localparam int A_RAW0   = 'h200;
  localparam int A_PCLR0  = 'h280;
  localparam int A_ENW1S0 = 'h300;
  localparam int A_ENW1C0 = 'h380;
  localparam int A_POL0   = 'hD00;
  localparam int A_TYP0   = 'hD80;
endpackage

// File: rtl/ecr_wdec.sv
module ecr_wdec
  import ecr_pkg::*;
#(
  parameter int NUM_EVT  = 64,
  parameter int NUM_HOST = 10,
  parameter int AW       = 12,
  localparam int NWORD   = NUM_EVT / 32
) (
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [31:0]         wdata,
  output logic [NUM_EVT-1:0]  pset,
  output logic [NUM_EVT-1:0]  pclr,
  output logic [NUM_EVT-1:0]  eset,
  output logic [NUM_EVT-1:0]  eclr,
  output logic [NUM_HOST-1:0] hset,
  output logic [NUM_HOST-1:0] hclr,
  output logic                glb_we,
  output logic [NWORD-1:0]    pol_we,
  output logic [NWORD-1:0]    typ_we
);
  localparam int EIW = $clog2(NUM_EVT);
  localparam int HIW = $clog2(NUM_HOST);
  localparam logic [NUM_EVT-1:0]  EVT_ONE  = NUM_EVT'(1);
  localparam logic [NUM_HOST-1:0] HOST_ONE = NUM_HOST'(1);

  logic [NUM_EVT-1:0]  evt_one;
  logic [NUM_HOST-1:0] host_one;

  // Index decode: out-of-range numbers give an empty mask
  always_comb begin
    evt_one  = (wdata < 32'(NUM_EVT))  ? (EVT_ONE << wdata[EIW-1:0])  : '0;
    host_one = (wdata < 32'(NUM_HOST)) ? (HOST_ONE << wdata[HIW-1:0]) : '0;
  end

  always_comb begin
    pset   = (we && addr == AW'(A_STSET)) ? evt_one : '0;
    pclr   = (we && addr == AW'(A_STCLR)) ? evt_one : '0;
    eset   = (we && addr == AW'(A_ENSET)) ? evt_one : '0;
    eclr   = (we && addr == AW'(A_ENCLR)) ? evt_one : '0;
    hset   = (we && addr == AW'(A_HSET))  ? host_one : '0;
    hclr   = (we && addr == AW'(A_HCLR))  ? host_one : '0;
    glb_we = we && addr == AW'(A_GLB);
    for (int w = 0; w < NWORD; w++) begin
      if (we && addr == AW'(A_PCLR0 + 4*w))  pclr[w*32 +: 32] = pclr[w*32 +: 32] | wdata;
      if (we && addr == AW'(A_ENW1S0 + 4*w)) eset[w*32 +: 32] = eset[w*32 +: 32] | wdata;
      if (we && addr == AW'(A_ENW1C0 + 4*w)) eclr[w*32 +: 32] = eclr[w*32 +: 32] | wdata;
      pol_we[w] = we && addr == AW'(A_POL0 + 4*w);
      typ_we[w] = we && addr == AW'(A_TYP0 + 4*w);
    end
  end
endmodule

// File: rtl/ecr_edge.sv
module ecr_edge #(
  parameter int NUM_EVT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [NUM_EVT-1:0] pol,
  input  logic [NUM_EVT-1:0] typ,
  output logic [NUM_EVT-1:0] hw_set
);
  logic [NUM_EVT-1:0] act;
  logic [NUM_EVT-1:0] act_q;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_line
    // polarity 1: high is active; polarity 0: low is active
    assign act[i]    = evt_in[i] ~^ pol[i];
    // mode 1: level, mode 0: inactive-to-active transition
    assign hw_set[i] = typ[i] ? act[i] : (act[i] & ~act_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act;
  end
endmodule

// File: rtl/ecr_state.sv
module ecr_state #(
  parameter int NUM_EVT  = 64,
  parameter int NUM_HOST = 10,
  localparam int NWORD   = NUM_EVT / 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EVT-1:0]  pset,
  input  logic [NUM_EVT-1:0]  pclr,
  input  logic [NUM_EVT-1:0]  hw_set,
  input  logic [NUM_EVT-1:0]  eset,
  input  logic [NUM_EVT-1:0]  eclr,
  input  logic [NUM_HOST-1:0] hset,
  input  logic [NUM_HOST-1:0] hclr,
  input  logic                glb_we,
  input  logic [NWORD-1:0]    pol_we,
  input  logic [NWORD-1:0]    typ_we,
  input  logic [31:0]         wdata,
  output logic [NUM_EVT-1:0]  pend,
  output logic [NUM_EVT-1:0]  en,
  output logic [NUM_HOST-1:0] host,
  output logic                glb,
  output logic [NUM_EVT-1:0]  pol,
  output logic [NUM_EVT-1:0]  typ
);
  logic [NUM_EVT-1:0]  pend_nx, en_nx, pol_nx, typ_nx;
  logic [NUM_HOST-1:0] host_nx;
  logic                glb_nx;
  logic                pend_ce, en_ce, host_ce, cfg_ce;

  // Next state: sets are applied after clears, so a set always wins
  always_comb begin
    pend_nx = (pend & ~pclr) | pset | hw_set;
    en_nx   = (en & ~eclr) | eset;
    host_nx = (host & ~hclr) | hset;
    glb_nx  = glb_we ? wdata[0] : glb;
    pol_nx  = pol;
    typ_nx  = typ;
    for (int w = 0; w < NWORD; w++) begin
      if (pol_we[w]) pol_nx[w*32 +: 32] = wdata;
      if (typ_we[w]) typ_nx[w*32 +: 32] = wdata;
    end
    pend_ce = |{pset, pclr, hw_set};
    en_ce   = |{eset, eclr};
    host_ce = |{hset, hclr};
    cfg_ce  = |{pol_we, typ_we};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
      host <= '0;
      glb  <= 1'b0;
      pol  <= '1;
      typ  <= '0;
    end else begin
      if (pend_ce) pend <= pend_nx;
      if (en_ce)   en   <= en_nx;
      if (host_ce) host <= host_nx;
      if (glb_we)  glb  <= glb_nx;
      if (cfg_ce) begin
        pol <= pol_nx;
        typ <= typ_nx;
      end
    end
  end

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((pend & $past(hw_set)) == $past(hw_set)));  // R12
endmodule

// File: rtl/ecr_rdmux.sv
module ecr_rdmux
  import ecr_pkg::*;
#(
  parameter int NUM_EVT = 64,
  parameter int AW      = 12,
  localparam int NWORD  = NUM_EVT / 32
) (
  input  logic [AW-1:0]      addr,
  input  logic [NUM_EVT-1:0] pend,
  input  logic [NUM_EVT-1:0] en,
  input  logic               glb,
  input  logic [NUM_EVT-1:0] pol,
  input  logic [NUM_EVT-1:0] typ,
  output logic [31:0]        rdata
);
  always_comb begin
    rdata = '0;
    if (addr == AW'(A_GLB)) rdata = {31'd0, glb};
    for (int w = 0; w < NWORD; w++) begin
      if (addr == AW'(A_RAW0 + 4*w) || addr == AW'(A_PCLR0 + 4*w))
        rdata = pend[w*32 +: 32];
      if (addr == AW'(A_ENW1S0 + 4*w) || addr == AW'(A_ENW1C0 + 4*w))
        rdata = en[w*32 +: 32];
      if (addr == AW'(A_POL0 + 4*w)) rdata = pol[w*32 +: 32];
      if (addr == AW'(A_TYP0 + 4*w)) rdata = typ[w*32 +: 32];
    end
  end
endmodule

// File: rtl/evt_ctl_regbank.sv
module evt_ctl_regbank
  import ecr_pkg::*;
#(
  parameter int NUM_EVT  = 64,   // multiple of 32
  parameter int NUM_HOST = 10,
  parameter int AW       = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_EVT-1:0]  evt_in,
  output logic [NUM_EVT-1:0]  evt_pend,
  output logic [NUM_EVT-1:0]  evt_en,
  output logic [NUM_HOST-1:0] host_en,
  output logic                glb_en
);
  localparam int NWORD = NUM_EVT / 32;
  localparam int EIW   = $clog2(NUM_EVT);

  logic [1:0] rst_sync;
  logic       rst_int_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [NUM_EVT-1:0]  pset, pclr, eset, eclr, hw_set, pol, typ;
  logic [NUM_HOST-1:0] hset, hclr;
  logic                glb_we;
  logic [NWORD-1:0]    pol_we, typ_we;

  ecr_wdec #(.NUM_EVT(NUM_EVT), .NUM_HOST(NUM_HOST), .AW(AW)) u_wdec (
    .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .pset(pset), .pclr(pclr), .eset(eset), .eclr(eclr),
    .hset(hset), .hclr(hclr), .glb_we(glb_we),
    .pol_we(pol_we), .typ_we(typ_we)
  );

  ecr_edge #(.NUM_EVT(NUM_EVT)) u_edge (
    .clk(clk), .rst_n(rst_int_n), .evt_in(evt_in),
    .pol(pol), .typ(typ), .hw_set(hw_set)
  );

  ecr_state #(.NUM_EVT(NUM_EVT), .NUM_HOST(NUM_HOST)) u_state (
    .clk(clk), .rst_n(rst_int_n),
    .pset(pset), .pclr(pclr), .hw_set(hw_set),
    .eset(eset), .eclr(eclr), .hset(hset), .hclr(hclr),
    .glb_we(glb_we), .pol_we(pol_we), .typ_we(typ_we), .wdata(bus_wdata),
    .pend(evt_pend), .en(evt_en), .host(host_en), .glb(glb_en),
    .pol(pol), .typ(typ)
  );

  ecr_rdmux #(.NUM_EVT(NUM_EVT), .AW(AW)) u_rdmux (
    .addr(bus_addr), .pend(evt_pend), .en(evt_en), .glb(glb_en),
    .pol(pol), .typ(typ), .rdata(bus_rdata)
  );

  AST_IDX_SET_PEND: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_we && bus_addr == AW'(A_STSET) && bus_wdata < 32'(NUM_EVT))
    |=> evt_pend[$past(bus_wdata[EIW-1:0])]);  // R2

  AST_IDX_EN_CLR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_we && bus_addr == AW'(A_ENCLR) && bus_wdata < 32'(NUM_EVT))
    |=> !evt_en[$past(bus_wdata[EIW-1:0])]);  // R3

  AST_HOST_OOR_IGN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_we && (bus_addr == AW'(A_HSET) || bus_addr == AW'(A_HCLR))
     && bus_wdata >= 32'(NUM_HOST)) |=> $stable(host_en));  // R5

  AST_GLB_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(bus_we && bus_addr == AW'(A_GLB)) |=> $stable(glb_en));  // R6

  AST_W1S_NO_CLR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_we && (bus_addr == AW'(A_ENW1S0) || bus_addr == AW'(A_ENW1S0 + 4)))
    |=> ((evt_en & $past(evt_en)) == $past(evt_en)));  // R7
endmodule

// File: tb/evt_ctl_regbank_tb.sv
`timescale 1ns/1ps
module evt_ctl_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] evt_in;
  logic [63:0] evt_pend;
  logic [63:0] evt_en;
  logic [9:0]  host_en;
  logic        glb_en;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  evt_ctl_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .evt_pend(evt_pend), .evt_en(evt_en), .host_en(host_en), .glb_en(glb_en)
  );

  // {is_write, addr, data (write data or expected read), requirement number}
  localparam int NV = 38;
  localparam logic [52:0] VEC [NV] = '{
    {1'b1, 12'h020, 32'd5,          8'd2},   // R2 set event 5
    {1'b0, 12'h200, 32'h0000_0020,  8'd2},
    {1'b1, 12'h020, 32'd40,         8'd2},   // R2 upper word
    {1'b0, 12'h204, 32'h0000_0100,  8'd13},  // R13 raw status
    {1'b1, 12'h024, 32'd5,          8'd2},
    {1'b0, 12'h200, 32'h0,          8'd2},
    {1'b1, 12'h020, 32'd64,         8'd5},   // R5 first illegal event
    {1'b0, 12'h200, 32'h0,          8'd5},
    {1'b0, 12'h204, 32'h0000_0100,  8'd5},
    {1'b1, 12'h028, 32'd3,          8'd3},   // R3
    {1'b0, 12'h300, 32'h0000_0008,  8'd3},
    {1'b1, 12'h300, 32'h0000_0030,  8'd7},   // R7
    {1'b0, 12'h300, 32'h0000_0038,  8'd7},
    {1'b1, 12'h300, 32'h0,          8'd7},
    {1'b0, 12'h380, 32'h0000_0038,  8'd7},
    {1'b1, 12'h380, 32'h0000_0010,  8'd8},   // R8
    {1'b0, 12'h300, 32'h0000_0028,  8'd8},
    {1'b1, 12'h02C, 32'd3,          8'd3},
    {1'b0, 12'h300, 32'h0000_0020,  8'd3},
    {1'b1, 12'h304, 32'h8000_0000,  8'd7},
    {1'b0, 12'h384, 32'h8000_0000,  8'd7},
    {1'b1, 12'h02C, 32'd99,         8'd5},
    {1'b0, 12'h384, 32'h8000_0000,  8'd5},
    {1'b1, 12'h284, 32'h0000_0100,  8'd8},
    {1'b0, 12'h204, 32'h0,          8'd8},
    {1'b1, 12'h010, 32'hFFFF_FFFF,  8'd6},   // R6
    {1'b0, 12'h010, 32'h0000_0001,  8'd6},
    {1'b1, 12'h010, 32'h0,          8'd6},
    {1'b0, 12'h010, 32'h0,          8'd6},
    {1'b1, 12'hD80, 32'h0000_000F,  8'd9},   // R9
    {1'b0, 12'hD80, 32'h0000_000F,  8'd9},
    {1'b1, 12'hD84, 32'h0000_A5A5,  8'd9},
    {1'b0, 12'hD84, 32'h0000_A5A5,  8'd9},
    {1'b1, 12'hD84, 32'h0,          8'd9},
    {1'b1, 12'hD80, 32'h0,          8'd9},
    {1'b0, 12'hD80, 32'h0,          8'd9},
    {1'b0, 12'h444, 32'h0,          8'd13},  // R13 unmapped
    {1'b0, 12'h020, 32'h0,          8'd13}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1;
    chk(req, {32'd0, bus_rdata}, {32'd0, exp});
  endtask

  task automatic line(input int n, input logic v);
    @(negedge clk);
    evt_in[n] = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; evt_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", evt_pend, 64'd0);
    chk("R1", evt_en, 64'd0);
    chk("R1", {53'd0, host_en, glb_en}, 64'd0);
    rd("R1", 12'hD04, 32'hFFFF_FFFF);
    rd("R1", 12'hD80, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][52]) wr(VEC[i][51:40], VEC[i][39:8]);
      else            rd($sformatf("R%0d", VEC[i][7:0]), VEC[i][51:40], VEC[i][39:8]);
    end

    // R4 / R5 host enables
    wr(12'h034, 32'd9);  chk("R4", {54'd0, host_en}, 64'h200);
    wr(12'h034, 32'd10); chk("R5", {54'd0, host_en}, 64'h200);
    wr(12'h034, 32'd0);  chk("R4", {54'd0, host_en}, 64'h201);
    wr(12'h038, 32'd9);  chk("R4", {54'd0, host_en}, 64'h001);
    wr(12'h038, 32'd15); chk("R5", {54'd0, host_en}, 64'h001);
    wr(12'h010, 32'd1);  chk("R6", {63'd0, glb_en}, 64'd1);

    // R10 pulse mode
    line(7, 1'b1);       chk("R10", {63'd0, evt_pend[7]}, 64'd1);
    wr(12'h024, 32'd7);
    @(negedge clk);      chk("R10", {63'd0, evt_pend[7]}, 64'd0);
    line(7, 1'b0);
    // R12 line edge and clear in the same cycle
    @(negedge clk);
    evt_in[7] = 1'b1; bus_addr = 12'h024; bus_wdata = 32'd7; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    chk("R12", {63'd0, evt_pend[7]}, 64'd1);
    evt_in[7] = 1'b0;
    wr(12'h024, 32'd7);  chk("R12", {63'd0, evt_pend[7]}, 64'd0);

    // R11 level mode on event 12
    wr(12'hD80, 32'h0000_1000);
    line(12, 1'b1);      chk("R11", {63'd0, evt_pend[12]}, 64'd1);
    wr(12'h024, 32'd12); chk("R11", {63'd0, evt_pend[12]}, 64'd1);
    line(12, 1'b0);      chk("R11", {63'd0, evt_pend[12]}, 64'd1);
    wr(12'h024, 32'd12); chk("R11", {63'd0, evt_pend[12]}, 64'd0);

    // R9 active-low polarity on event 20
    line(20, 1'b1);
    wr(12'h024, 32'd20);
    wr(12'hD00, 32'hFFEF_FFFF);
    chk("R9", {63'd0, evt_pend[20]}, 64'd0);
    line(20, 1'b0);      chk("R9", {63'd0, evt_pend[20]}, 64'd1);
    rd("R13", 12'h200, 32'h0010_0000);

    chk("R3", evt_en, 64'h8000_0000_0000_0020);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule